// File: doc/BRIEF.md
# Glitch-Free Selectable Card Clock Divider

This block derives the card clock from a fast clock. It divides by 1, 2, 4 or 8, chosen with a two-bit select. The fast clock runs at twice the reference rate. Ratio N therefore gives a card clock whose high and low phases each last N fast-clock cycles, so the period is 2N cycles. The output comes straight from a flop, so it carries no combinational glitch.

The select inputs and the enable from the session sequencer are asynchronous to the fast clock, so both pass through synchronizers first. A select code must stay steady for a settle window before it is accepted. A code that shows up only briefly, as when the two select bits change at slightly different times, is therefore discarded.

The accepted ratio and the enable are both applied only at the common 16-cycle boundary of the free-running phase counter. Every divider tap is low at that boundary. Ratio switches, starts and stops therefore always fall at the edge where the output goes low, and no phase is ever cut short.

Top module: `card_clk_divider`

## Requirements
- R1: Select code 2'b00, 2'b01, 2'b10 and 2'b11 gives steady-state high and low phases of 1, 2, 4 and 8 fast-clock cycles respectively.
- R2: While rst_ni is low, and after reset for as long as clk_en_i stays low, card_clk_o is low.
- R3: When clk_en_i goes low, the output stops only at a phase boundary: every high phase, including the last one, has full width. After that the output stays low.
- R4: When clk_en_i goes high, the output starts with full-width phases at the selected ratio.
- R5: A ratio change takes effect only where the output falls. Every high or low phase around the change lasts exactly the half-period of either the old ratio or the new ratio, so no runt pulse occurs.
- R6: A select code is accepted only after it has been seen steady for 8 consecutive synchronized cycles. An intermediate code held for only a few cycles never appears in the output. A code held long enough does appear.
- R7: Every high phase of card_clk_o lasts 1, 2, 4 or 8 fast-clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock (twice the reference rate) |
| rst_ni | input | 1 | Active-low asynchronous reset |
| div_sel_i | input | 2 | Ratio select: 0 for /1, 1 for /2, 2 for /4, 3 for /8 |
| clk_en_i | input | 1 | Clock gate from the session sequencer, active high |
| card_clk_o | output | 1 | Card clock |

## Verification
The bench measures the length of every high and low phase at the output and keeps, for each level, a set of the lengths seen plus a flag for any length that is not a legal ratio.

It runs four kinds of pattern:
- Steady runs at each of the four codes. These separate the ratios from one another.
- A sweep over all twelve ordered pairs of distinct codes. This tells a clean switch apart from one that leaves a third, truncated phase length.
- Brief and long intermediate codes. These show whether the settle filter rejects the brief code while still admitting a real change.
- Enable and disable edges. These show whether the gate cuts a pulse short.

// File: rtl/ccd_pkg.sv
package ccd_pkg;
  localparam int unsigned DEF_STEPS  = 4;
  localparam int unsigned DEF_SETTLE = 8;
  localparam int unsigned DEF_SYNC   = 2;

  // half-period in fast cycles for a select code
  function automatic int unsigned half_period(input int unsigned code);
    return 1 << code;
  endfunction
endpackage

// File: rtl/ccd_sync.sv
module ccd_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/ccd_sel_filter.sv
module ccd_sel_filter #(
  parameter int unsigned SEL_W     = 2,
  parameter int unsigned SETTLE    = 8,
  parameter logic [SEL_W-1:0] RST_SEL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic [SEL_W-1:0] sel_o
);
  localparam int unsigned CW = (SETTLE > 1) ? $clog2(SETTLE) : 1;
  localparam logic [CW-1:0] LAST = CW'(SETTLE - 1);

  logic [SEL_W-1:0] seen_q;
  logic [CW-1:0]    hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= RST_SEL;
      hold_q <= '0;
      sel_o  <= RST_SEL;
    end else if (sel_i != seen_q) begin
      seen_q <= sel_i;
      hold_q <= '0;
    end else if (hold_q != LAST) begin
      hold_q <= hold_q + 1'b1;
    end else begin
      sel_o <= seen_q;
    end
  end
endmodule

// File: rtl/ccd_phase_gen.sv
module ccd_phase_gen #(
  parameter int unsigned STEPS = 4,
  parameter int unsigned SEL_W = 2,
  parameter logic [SEL_W-1:0] RST_SEL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             en_i,
  output logic [SEL_W-1:0] ratio_o,
  output logic             gate_o,
  output logic             clk_o
);
  logic [STEPS-1:0] cnt_q, cnt_n;
  logic [SEL_W-1:0] ratio_n;
  logic             gate_n, wrap;

  // all taps fall together when the counter wraps
  assign wrap  = &cnt_q;
  assign cnt_n = cnt_q + 1'b1;

  always_comb begin
    ratio_n = ratio_o;
    gate_n  = gate_o;
    if (wrap) begin
      ratio_n = sel_i;
      gate_n  = en_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ratio_o <= RST_SEL;
      gate_o  <= 1'b0;
      clk_o   <= 1'b0;
    end else begin
      cnt_q   <= cnt_n;
      ratio_o <= ratio_n;
      gate_o  <= gate_n;
      clk_o   <= gate_n & cnt_n[ratio_n];
    end
  end
endmodule

// File: rtl/card_clk_divider.sv
module card_clk_divider #(
  parameter int unsigned DIV_STEPS   = ccd_pkg::DEF_STEPS,
  parameter int unsigned SETTLE      = ccd_pkg::DEF_SETTLE,
  parameter int unsigned SYNC_STAGES = ccd_pkg::DEF_SYNC,
  localparam int unsigned SEL_W      = $clog2(DIV_STEPS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] div_sel_i,
  input  logic             clk_en_i,
  output logic             card_clk_o
);
  localparam logic [SEL_W-1:0] RST_SEL = SEL_W'(DIV_STEPS - 1);

  logic [SEL_W-1:0] sel_s, sel_acc, ratio_q;
  logic             en_s, gate_q;

  ccd_sync #(.W(SEL_W), .STAGES(SYNC_STAGES)) u_sel_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(div_sel_i), .q_o(sel_s)
  );

  ccd_sync #(.W(1), .STAGES(SYNC_STAGES)) u_en_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(clk_en_i), .q_o(en_s)
  );

  ccd_sel_filter #(.SEL_W(SEL_W), .SETTLE(SETTLE), .RST_SEL(RST_SEL)) u_filter (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_s), .sel_o(sel_acc)
  );

  ccd_phase_gen #(.STEPS(DIV_STEPS), .SEL_W(SEL_W), .RST_SEL(RST_SEL)) u_phase (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_acc), .en_i(en_s),
    .ratio_o(ratio_q), .gate_o(gate_q), .clk_o(card_clk_o)
  );
endmodule

// File: rtl/card_clk_divider_chk.sv
module card_clk_divider_chk #(
  parameter int unsigned SEL_W  = 2,
  parameter int unsigned SETTLE = 8,
  parameter int unsigned MAX_HP = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             card_clk_o,
  input logic [SEL_W-1:0] ratio_q,
  input logic             gate_q,
  input logic [SEL_W-1:0] sel_s,
  input logic [SEL_W-1:0] sel_acc
);
  logic [5:0] hi_len;
  logic [5:0] st_len;
  logic [SEL_W-1:0] sel_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_len   <= '0;
      st_len   <= '0;
      sel_prev <= '0;
    end else begin
      hi_len   <= card_clk_o ? ((hi_len == 6'h3f) ? hi_len : hi_len + 1'b1) : '0;
      sel_prev <= sel_s;
      st_len   <= (sel_s != sel_prev) ? '0 : ((st_len == 6'h3f) ? st_len : st_len + 1'b1);
    end
  end

  a_r7_high_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(card_clk_o) |-> ($countones(hi_len) == 1 && hi_len <= 6'(MAX_HP)));

  a_r5_switch_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ratio_q) |-> !card_clk_o);

  a_r3_gate_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(gate_q) |-> !card_clk_o);

  a_r2_rise_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(card_clk_o) |-> gate_q);

  a_r6_settled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sel_acc) |-> (sel_acc == $past(sel_s) && st_len >= 6'(SETTLE / 2)));
endmodule

bind card_clk_divider card_clk_divider_chk #(.SEL_W(SEL_W), .SETTLE(SETTLE), .MAX_HP(1 << (DIV_STEPS - 1))) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .card_clk_o(card_clk_o), .ratio_q(ratio_q),
  .gate_q(gate_q), .sel_s(sel_s), .sel_acc(sel_acc)
);

// File: tb/card_clk_divider_test.sv
`timescale 1ns/1ps
module card_clk_divider_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] sel = 2'b00;
  logic       en = 1'b0;
  logic       cclk;

  int total = 0, bad = 0;
  bit done = 0;

  card_clk_divider uut (
    .clk_i(clk), .rst_ni(rst_n), .div_sel_i(sel), .clk_en_i(en), .card_clk_o(cclk)
  );

  always #4 clk = ~clk;

  // phase-length monitor
  logic       prev_lvl = 1'b0;
  int         run = 0;
  bit         skip = 1;
  logic [3:0] seen_hi = '0, seen_lo = '0;
  bit         odd = 0;
  int         hi_cnt = 0;

  always @(negedge clk) begin
    if (cclk) hi_cnt++;
    if (cclk !== prev_lvl) begin
      if (!skip) begin
        if (run == 1 || run == 2 || run == 4 || run == 8) begin
          if (prev_lvl) seen_hi[$clog2(run)] = 1'b1;
          else          seen_lo[$clog2(run)] = 1'b1;
        end else odd = 1;
      end
      skip = 0;
      run = 1;
      prev_lvl = cclk;
    end else run++;
  end

  task automatic clr();
    @(negedge clk); #1;
    skip = 1; seen_hi = '0; seen_lo = '0; odd = 0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int h0;
    // R2 reset state
    repeat (5) @(negedge clk);
    check(cclk == 1'b0, "R2 during reset", cclk, 0);
    cyc(1); rst_n = 1'b1;
    h0 = hi_cnt; cyc(50);
    check(hi_cnt == h0, "R2 idle after reset", hi_cnt - h0, 0);

    // R1 steady ratios
    en = 1'b1;
    for (int s = 0; s < 4; s++) begin
      sel = 2'(s); cyc(60); clr(); cyc(80);
      check(seen_hi == 4'(1 << s) && seen_lo == 4'(1 << s) && !odd, "R1 steady ratio",
            {seen_hi, seen_lo}, {4'(1 << s), 4'(1 << s)});
    end

    // R5 all transitions
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        if (a != b) begin
          logic [3:0] allow, all;
          sel = 2'(a); cyc(60);
          sel = 2'(b); clr(); cyc(80);
          allow = 4'(1 << a) | 4'(1 << b);
          all = seen_hi | seen_lo;
          check(((all & ~allow) == 0) && !odd && seen_hi[b] && seen_lo[b], "R5 ratio switch",
                {odd, all}, allow);
        end
      end
    end

    // R6 brief intermediate code rejected
    sel = 2'b00; cyc(60); clr();
    sel = 2'b01; cyc(3); sel = 2'b11; cyc(80);
    check(!seen_hi[1] && !seen_lo[1] && seen_hi[3] && !odd, "R6 brief code up",
          {seen_hi, seen_lo}, 8'h88);
    clr();
    sel = 2'b10; cyc(3); sel = 2'b00; cyc(80);
    check(!seen_hi[2] && !seen_lo[2] && seen_hi[0] && !odd, "R6 brief code down",
          {seen_hi, seen_lo}, 8'h11);
    // R6 long-held code accepted
    clr();
    sel = 2'b01; cyc(40); sel = 2'b11; cyc(80);
    check(seen_hi[1] && seen_lo[1] && !odd, "R6 held code", {seen_hi, seen_lo}, 8'h22);

    // R3 disable
    sel = 2'b11; cyc(60); clr();
    cyc(5); en = 1'b0; cyc(60);
    check((seen_hi & 4'b0111) == 0 && !odd, "R3 last pulse full", seen_hi, 8);
    h0 = hi_cnt; cyc(60);
    check(hi_cnt == h0, "R3 stays low", hi_cnt - h0, 0);

    // R4 enable start
    clr(); en = 1'b1; cyc(80);
    check(seen_hi == 4'b1000 && seen_lo == 4'b1000 && !odd, "R4 clean start",
          {seen_hi, seen_lo}, 8'h88);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule